// File: doc/BRIEF.md
# PSRAM Standby Mode Controller

This block sequences the low-power states of a pseudo-static RAM. It watches an active-low sleep pin and a one-bit sleep-select field of the configuration register. From these it moves the device between normal operation, partial-array refresh and deep power-down. Its outputs drive the refresh engine enable, a gate that refuses read and write commands, and a ready flag.

Standby is entered only after the sleep pin has stayed low for a qualifying time. The select bit picks the mode: 1 gives partial-array refresh and 0 gives deep power-down. Leaving partial-array refresh is immediate. Leaving deep power-down starts a fixed initialization wait, and commands stay refused until that wait ends.

The configuration register can be written in two ways. One is a pin-qualified write, made while the sleep pin is low. The other is a software-access write. A software-access write locks out pin-initiated partial-array refresh until the next power-up reset. When such a write sets the select bit, it also enters partial-array refresh at once. Both the qualifying time and the wait are given in microseconds and converted to clock cycles from the clock frequency parameter.

Top module: `psram_sleep_ctrl`

## Requirements
- R1: After reset: `ready`=1, `cmd_block`=0, `refresh_en`=1, `sw_locked`=0, and `sel_bit` equals parameter SEL_RESET.
- R2: With N = CLK_MHZ*ENTRY_US, a sleep pin sampled low on N consecutive rising edges causes no mode change. The (N+1)th consecutive low sample enters standby on that edge.
- R3: Pin-entered standby with `sel_bit`=1 is partial-array refresh, with `refresh_en` equal to parameter PAR_FULL. A low-to-high transition of the sleep pin returns to normal on the edge that samples it high.
- R4: Pin-entered standby with `sel_bit`=0 is deep power-down, with `refresh_en`=0.
- R5: A low-to-high transition of the sleep pin in deep power-down starts initialization. With M = CLK_MHZ*INIT_US, `ready` stays 0 and `refresh_en`=1 for exactly M cycles, then `ready` returns to 1.
- R6: `cmd_block` is 1 and `ready` is 0 in partial-array refresh, in deep power-down and during initialization.
- R7: `cfg_hw_wr` in normal mode while `sleep_n` is low loads `cfg_sel_in` into `sel_bit` and leaves `sw_locked` unchanged. This holds both before and after the lockout.
- R8: A software-access write (`cfg_wr`) in normal mode sets `sw_locked`. The flag stays set until reset. While it is set, a qualified low pin with `sel_bit`=1 causes no mode change.
- R9: A software-access write with `cfg_sel_in`=1 loads `sel_bit` and enters partial-array refresh on the same edge, without any pin qualification.
- R10: A software-access write with `cfg_sel_in`=0 loads `sel_bit` and stays in normal mode. A later qualified pin low still enters deep power-down.
- R11: `cfg_wr` and `cfg_hw_wr` have no effect on `sel_bit` or `sw_locked` outside normal mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-up reset |
| sleep_n | input | 1 | Active-low sleep pin |
| cfg_wr | input | 1 | Software-access configuration write strobe |
| cfg_hw_wr | input | 1 | Pin-qualified configuration write strobe |
| cfg_sel_in | input | 1 | Sleep-select value carried by either write |
| ready | output | 1 | Device in normal mode, accepting commands |
| cmd_block | output | 1 | Read and write commands refused |
| refresh_en | output | 1 | Refresh engine enable |
| sel_bit | output | 1 | Current sleep-select bit (1 = partial refresh, 0 = deep power-down) |
| sw_locked | output | 1 | Pin-initiated partial refresh disabled by a software write |

## Verification
The bench builds the controller with CLK_MHZ=2 and otherwise default parameters. The 10 µs qualifier therefore becomes 20 cycles and the 150 µs wait becomes 300 cycles. This puts the off-by-one boundary of the low-time qualifier, and the exact last blocked cycle of initialization, within a short directed run. PAR_FULL=1 and SEL_RESET=0 are kept, so the first pin-qualified entry goes to deep power-down unless a write changes the select bit first. A second power-up reset near the end shows that the lockout clears.

// File: rtl/psram_sleep_pkg.sv
package psram_sleep_pkg;

  typedef enum logic [1:0] {
    ST_NORMAL = 2'd0,
    ST_PAR    = 2'd1,
    ST_DPD    = 2'd2,
    ST_INIT   = 2'd3
  } sleep_state_t;

  function automatic int unsigned us_to_cycles(input int unsigned mhz, input int unsigned us);
    return mhz * us;
  endfunction

  function automatic logic refresh_for(input sleep_state_t st, input logic par_full);
    case (st)
      ST_DPD:  return 1'b0;
      ST_PAR:  return par_full;
      default: return 1'b1;
    endcase
  endfunction

endpackage

// File: rtl/psram_cycle_timer.sv
module psram_cycle_timer #(
  parameter int unsigned LIMIT = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic hit
);
  localparam int unsigned W = (LIMIT < 1) ? 1 : $clog2(LIMIT + 1);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (!run) begin
      cnt_q <= '0;
    end else if (cnt_q != W'(LIMIT)) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign hit = run && (cnt_q == W'(LIMIT));
endmodule

// File: rtl/psram_sleep_ctrl.sv
module psram_sleep_ctrl
  import psram_sleep_pkg::*;
#(
  parameter int unsigned CLK_MHZ   = 100,
  parameter int unsigned ENTRY_US  = 10,
  parameter int unsigned INIT_US   = 150,
  parameter bit          SEL_RESET = 1'b0,
  parameter bit          PAR_FULL  = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sleep_n,
  input  logic cfg_wr,
  input  logic cfg_hw_wr,
  input  logic cfg_sel_in,
  output logic ready,
  output logic cmd_block,
  output logic refresh_en,
  output logic sel_bit,
  output logic sw_locked
);
  localparam int unsigned ENTRY_CYC = us_to_cycles(CLK_MHZ, ENTRY_US);
  localparam int unsigned INIT_CYC  = us_to_cycles(CLK_MHZ, INIT_US);
  localparam int unsigned INIT_LIM  = (INIT_CYC < 1) ? 0 : INIT_CYC - 1;

  sleep_state_t st_q, st_d;
  logic sel_q, sel_d, lock_q, lock_d, sleep_q;

  // named internal events
  logic pin_qualified, pin_rise, init_done, pin_entry, sw_par_entry, hw_wr_ok;

  psram_cycle_timer #(.LIMIT(ENTRY_CYC)) u_entry_timer (
    .clk(clk), .rst_n(rst_n),
    .run(!sleep_n && (st_q == ST_NORMAL)),
    .hit(pin_qualified)
  );

  psram_cycle_timer #(.LIMIT(INIT_LIM)) u_init_timer (
    .clk(clk), .rst_n(rst_n),
    .run(st_q == ST_INIT),
    .hit(init_done)
  );

  assign pin_rise     = sleep_n && !sleep_q;
  assign pin_entry    = pin_qualified && (!sel_q || !lock_q);
  assign sw_par_entry = (st_q == ST_NORMAL) && !pin_entry && cfg_wr && cfg_sel_in;
  assign hw_wr_ok     = (st_q == ST_NORMAL) && !pin_entry && !cfg_wr && cfg_hw_wr && !sleep_n;

  always_comb begin
    st_d   = st_q;
    sel_d  = sel_q;
    lock_d = lock_q;
    case (st_q)
      ST_NORMAL: begin
        if (pin_entry) begin
          st_d = sel_q ? ST_PAR : ST_DPD;
        end else if (cfg_wr) begin
          sel_d  = cfg_sel_in;
          lock_d = 1'b1;
          if (cfg_sel_in) st_d = ST_PAR;
        end else if (hw_wr_ok) begin
          sel_d = cfg_sel_in;
        end
      end
      ST_PAR:  if (pin_rise)  st_d = ST_NORMAL;
      ST_DPD:  if (pin_rise)  st_d = ST_INIT;
      ST_INIT: if (init_done) st_d = ST_NORMAL;
      default: st_d = ST_NORMAL;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_NORMAL;
      sel_q   <= SEL_RESET;
      lock_q  <= 1'b0;
      sleep_q <= 1'b1;
    end else begin
      st_q    <= st_d;
      sel_q   <= sel_d;
      lock_q  <= lock_d;
      sleep_q <= sleep_n;
    end
  end

  assign ready      = (st_q == ST_NORMAL);
  assign cmd_block  = (st_q != ST_NORMAL);
  assign refresh_en = refresh_for(st_q, PAR_FULL);
  assign sel_bit    = sel_q;
  assign sw_locked  = lock_q;

  // Assertions
  assert_entry_qualified_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_NORMAL && !pin_qualified && !sw_par_entry) |=> ready);

  assert_par_exit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_PAR && pin_rise) |=> ready);

  assert_dpd_no_refresh_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_DPD) |-> !refresh_en);

  assert_init_blocked_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_INIT) |-> (cmd_block && !ready && refresh_en));

  assert_lock_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    sw_locked |=> sw_locked);

  assert_sw_par_R9: assert property (@(posedge clk) disable iff (!rst_n)
    sw_par_entry |=> (st_q == ST_PAR));

  assert_sw_no_dpd_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_NORMAL && cfg_wr && !pin_qualified) |=> (st_q != ST_DPD));

  assert_ignore_writes_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q != ST_NORMAL) |=> ($stable(sel_bit) && $stable(sw_locked)));
endmodule

// File: tb/test_psram_sleep_ctrl.sv
module test_psram_sleep_ctrl;
  localparam int unsigned MHZ = 2;
  localparam int unsigned N   = MHZ * 10;
  localparam int unsigned M   = MHZ * 150;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sleep_n = 1'b1, cfg_wr = 1'b0, cfg_hw_wr = 1'b0, cfg_sel_in = 1'b0;
  logic ready, cmd_block, refresh_en, sel_bit, sw_locked;
  int compared = 0, mismatched = 0;

  always #5 clk = ~clk;

  psram_sleep_ctrl #(.CLK_MHZ(MHZ), .ENTRY_US(10), .INIT_US(150),
                     .SEL_RESET(1'b0), .PAR_FULL(1'b1)) i_psram_sleep_ctrl (
    .clk(clk), .rst_n(rst_n), .sleep_n(sleep_n), .cfg_wr(cfg_wr),
    .cfg_hw_wr(cfg_hw_wr), .cfg_sel_in(cfg_sel_in), .ready(ready),
    .cmd_block(cmd_block), .refresh_en(refresh_en), .sel_bit(sel_bit),
    .sw_locked(sw_locked)
  );

  task automatic check(input string req, input logic act, input logic exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk) rst_n = 1'b0;
    sleep_n = 1'b1; cfg_wr = 1'b0; cfg_hw_wr = 1'b0;
    @(negedge clk) rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_reset();
    check("R1 ready", ready, 1'b1);
    check("R1 cmd_block", cmd_block, 1'b0);
    check("R1 refresh_en", refresh_en, 1'b1);
    check("R1 sw_locked", sw_locked, 1'b0);
    check("R1 sel_bit", sel_bit, 1'b0);
  endtask

  task automatic t_hw_write(input logic v);
    sleep_n = 1'b0; cfg_hw_wr = 1'b1; cfg_sel_in = v;
    @(negedge clk) cfg_hw_wr = 1'b0; sleep_n = 1'b1;
    @(negedge clk);
    check("R7 sel_bit", sel_bit, v);
    check("R7 ready", ready, 1'b1);
  endtask

  // hold pin low for n sampled edges; leave it low
  task automatic pin_low(input int n);
    sleep_n = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic t_short_pulse();
    pin_low(N);
    check("R2 short pulse ready", ready, 1'b1);
    sleep_n = 1'b1;
    @(negedge clk);
    check("R2 after short pulse", ready, 1'b1);
  endtask

  task automatic t_par_pin();
    pin_low(N + 1);
    check("R2 entry on N+1", ready, 1'b0);
    check("R6 cmd_block in PAR", cmd_block, 1'b1);
    check("R3 refresh in PAR", refresh_en, 1'b1);
    sleep_n = 1'b1;
    @(negedge clk);
    check("R3 immediate exit", ready, 1'b1);
  endtask

  task automatic t_dpd_pin();
    pin_low(N + 1);
    check("R4 ready in DPD", ready, 1'b0);
    check("R4 refresh off", refresh_en, 1'b0);
    // writes during DPD ignored
    cfg_hw_wr = 1'b1; cfg_sel_in = 1'b1;
    @(negedge clk) cfg_hw_wr = 1'b0; cfg_wr = 1'b1;
    @(negedge clk) cfg_wr = 1'b0;
    check("R11 sel_bit unchanged", sel_bit, 1'b0);
    check("R11 sw_locked unchanged", sw_locked, 1'b0);
    sleep_n = 1'b1;
    @(negedge clk);
    for (int i = 1; i < M; i++) begin
      if (i == 1) begin
        check("R5 init refresh on", refresh_en, 1'b1);
        check("R6 init blocked", cmd_block, 1'b1);
      end
      @(negedge clk);
    end
    check("R5 last init cycle blocked", ready, 1'b0);
    @(negedge clk);
    check("R5 ready after init", ready, 1'b1);
  endtask

  task automatic t_sw_par();
    cfg_wr = 1'b1; cfg_sel_in = 1'b1;
    @(negedge clk) cfg_wr = 1'b0;
    check("R9 sw write enters PAR", ready, 1'b0);
    check("R9 sel_bit", sel_bit, 1'b1);
    check("R8 lock set", sw_locked, 1'b1);
    sleep_n = 1'b0;
    @(negedge clk) sleep_n = 1'b1;
    @(negedge clk);
    check("R3 exit sw PAR", ready, 1'b1);
    pin_low(N + 5);
    check("R8 pin PAR locked out", ready, 1'b0 ^ 1'b1);
    cfg_hw_wr = 1'b1; cfg_sel_in = 1'b1;
    @(negedge clk) cfg_hw_wr = 1'b0;
    sleep_n = 1'b1;
    @(negedge clk);
    check("R7 hw write after lock", sel_bit, 1'b1);
    check("R8 still locked", sw_locked, 1'b1);
  endtask

  task automatic t_sw_zero();
    cfg_wr = 1'b1; cfg_sel_in = 1'b0;
    @(negedge clk) cfg_wr = 1'b0;
    check("R10 stays normal", ready, 1'b1);
    check("R10 sel_bit", sel_bit, 1'b0);
    pin_low(N + 1);
    check("R10 pin DPD after lock", refresh_en, 1'b0);
    sleep_n = 1'b1;
    repeat (M + 1) @(negedge clk);
    check("R10 ready after init", ready, 1'b1);
    check("R8 lock kept", sw_locked, 1'b1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    do_reset();
    t_reset();
    t_hw_write(1'b1);
    t_short_pulse();
    t_par_pin();
    t_hw_write(1'b0);
    t_dpd_pin();
    t_sw_par();
    t_sw_zero();
    do_reset();
    check("R8 lock cleared by reset", sw_locked, 1'b0);
    check("R1 sel reset", sel_bit, 1'b0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule